// File: doc/BRIEF.md
# ADC Controller Register Front-End

This block is the software-visible register set that sits between a 32-bit word-addressed bus and an abstract successive-approximation conversion core. Writing a channel number into the channel-control register is itself the start command: the block sends a one-cycle start request with that channel to the core. When the core later returns a result, the block stores it, sets a completion flag, and asserts an interrupt if the interrupt-enable bit is set. Writing the all-ones channel code instead puts the converter in its stop state, and any result still in flight is then discarded.

A calibration run is launched by setting a bit in general control. That bit stays set while the run lasts and clears itself when the core reports the end. The run's pass or fail outcome is latched in general status, and the completion flag and interrupt fire as for a conversion. The configuration register holds the resolution mode and an overwrite-enable bit. The resolution mode masks the result when it is read. The overwrite-enable bit decides whether a fresh result may replace one that software has not read yet.

Top module: `adc_regfront`

## Requirements
- R1: After reset, channel control (byte offset 0x00) reads 0x1F (stop code, interrupt disabled), every other register reads zero, and `irq` is low.
- R2: A write to offset 0x00 whose channel field (bits 4:0) is not 0x1F drives `core_start` high for exactly the one cycle after the write, with `core_chan` equal to that field. Bit 7 of the same write is the interrupt enable.
- R3: A write of channel field 0x1F starts nothing and cancels any conversion in flight. A `core_done` arriving while stopped leaves status and result unchanged.
- R4: A `core_done` for a started conversion sets status bit 0 (offset 0x08). `irq` equals status bit 0 AND the interrupt-enable bit.
- R5: A read of the result register (offset 0x0C) clears status bit 0, so `irq` is low from the next cycle, unless a new completion arrives in the same cycle.
- R6: With configuration bit 16 set, a new result replaces an unread one.
- R7: With configuration bit 16 clear and status bit 0 set, a new result is dropped and the old result stays.
- R8: The result read is masked by configuration bits 3:2. 00 gives 8 bits, 01 gives 10 bits, and 10 or 11 gives 12 bits.
- R9: Writing 1 to general control bit 7 (offset 0x18) while idle pulses `core_cal_start` for one cycle. Bit 7 then reads 1 until `core_cal_done`, after which it reads 0. Further writes during a run have no effect.
- R10: At calibration end, general status bit 1 (offset 0x1C) takes the value of `core_cal_fail`, and status bit 0 is set. Bit 1 clears when the next run starts.
- R11: Configuration keeps only bits 3:2 and 16, and pin control (offset 0x30) keeps all 32 bits. Reads of unmapped offsets return zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Completion interrupt |
| core_start | output | 1 | One-cycle conversion start request |
| core_chan | output | 5 | Channel for the conversion |
| core_done | input | 1 | Conversion finished, result valid |
| core_result | input | 12 | Raw conversion result |
| core_cal_start | output | 1 | One-cycle calibration start request |
| core_cal_done | input | 1 | Calibration finished |
| core_cal_fail | input | 1 | Calibration outcome, valid with done |

## Verification
Read data is combinational and is due within the access cycle. Register side effects (start pulses, flag set and clear, calibration state) take effect at the clock edge that ends the access, so `core_start` and `core_cal_start` are due one cycle after the write, and `irq` follows one cycle after a done or a result read. The bench keeps a behavioural model that advances on the same edges. It compares pulses and `irq` at every falling edge and checks read data shortly after the access is driven, so every expected value is sampled half a cycle away from the edge that produced it.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;

  localparam int unsigned CH_W   = 5;
  localparam int unsigned RES_W  = 12;
  localparam int unsigned WORD_W = 32;

  localparam logic [CH_W-1:0] CH_STOP = '1;

  localparam logic [7:0] OFF_CHCTL = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_RES   = 8'h0C;
  localparam logic [7:0] OFF_CFG   = 8'h14;
  localparam logic [7:0] OFF_GCTL  = 8'h18;
  localparam logic [7:0] OFF_GSTAT = 8'h1C;
  localparam logic [7:0] OFF_PIN   = 8'h30;

  typedef enum logic [1:0] {
    RES_8  = 2'b00,
    RES_10 = 2'b01,
    RES_12 = 2'b10
  } res_mode_e;

  function automatic logic [RES_W-1:0] res_mask(input logic [1:0] mode);
    case (mode)
      RES_8:   res_mask = RES_W'(12'h0FF);
      RES_10:  res_mask = RES_W'(12'h3FF);
      default: res_mask = '1;
    endcase
  endfunction

endpackage

// File: rtl/adc_regfront_conv.sv
module adc_regfront_conv
  import adc_regfront_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_we,
  input  logic [CH_W-1:0]  ch_code,
  input  logic             ch_ie,
  input  logic             rd_res,
  input  logic             cal_set,
  input  logic             ovw_en,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_result,
  output logic             core_start,
  output logic [CH_W-1:0]  chan_q,
  output logic             ie_q,
  output logic             flag_q,
  output logic [RES_W-1:0] result_q
);

  logic             busy_q, busy_n;
  logic             start_n;
  logic [CH_W-1:0]  chan_n;
  logic             ie_n, flag_n;
  logic [RES_W-1:0] result_n;
  logic             conv_end;

  assign conv_end = core_done && busy_q;

  always_comb begin
    start_n  = 1'b0;
    busy_n   = busy_q;
    chan_n   = chan_q;
    ie_n     = ie_q;
    flag_n   = flag_q;
    result_n = result_q;
    if (conv_end) begin
      busy_n = 1'b0;
      if (!flag_q || ovw_en || rd_res) result_n = core_result;
    end
    if (ch_we) begin
      chan_n = ch_code;
      ie_n   = ch_ie;
      if (ch_code != CH_STOP) begin
        start_n = 1'b1;
        busy_n  = 1'b1;
      end else begin
        busy_n  = 1'b0;
      end
    end
    if (rd_res) flag_n = 1'b0;
    if (conv_end || cal_set) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_start <= 1'b0;
      busy_q     <= 1'b0;
      chan_q     <= CH_STOP;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      result_q   <= '0;
    end else begin
      core_start <= start_n;
      busy_q     <= busy_n;
      chan_q     <= chan_n;
      ie_q       <= ie_n;
      flag_q     <= flag_n;
      result_q   <= result_n;
    end
  end

  assert_start_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(ch_we && ch_code != CH_STOP));

  assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(conv_end || cal_set));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !conv_end && !cal_set) |=> !flag_q);

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && flag_q && !ovw_en && !rd_res && !ch_we) |=> $stable(result_q));

  assert_stop_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !busy_q && !cal_set && !rd_res) |=> $stable(result_q) && $stable(flag_q));

endmodule

// File: rtl/adc_regfront_cal.sv
module adc_regfront_cal (
  input  logic clk,
  input  logic rst_n,
  input  logic gc_we,
  input  logic gc_cal,
  input  logic core_cal_done,
  input  logic core_cal_fail,
  output logic core_cal_start,
  output logic cal_run_q,
  output logic cal_fail_q,
  output logic cal_set
);

  logic run_n, fail_n, start_n;

  assign cal_set = core_cal_done && cal_run_q;

  always_comb begin
    run_n   = cal_run_q;
    fail_n  = cal_fail_q;
    start_n = 1'b0;
    if (gc_we && gc_cal && !cal_run_q) begin
      run_n   = 1'b1;
      fail_n  = 1'b0;
      start_n = 1'b1;
    end
    if (cal_set) begin
      run_n  = 1'b0;
      fail_n = core_cal_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_run_q      <= 1'b0;
      cal_fail_q     <= 1'b0;
      core_cal_start <= 1'b0;
    end else begin
      cal_run_q      <= run_n;
      cal_fail_q     <= fail_n;
      core_cal_start <= start_n;
    end
  end

  assert_cal_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_cal_start |-> cal_run_q && !$past(cal_run_q));

  assert_cal_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_run_q && core_cal_done) |=> !cal_run_q && (cal_fail_q == $past(core_cal_fail)));

endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
  import adc_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PIN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              core_start,
  output logic [4:0]        core_chan,
  input  logic              core_done,
  input  logic [11:0]       core_result,
  output logic              core_cal_start,
  input  logic              core_cal_done,
  input  logic              core_cal_fail
);

  localparam int unsigned CFG_OVW_BIT = 16;
  localparam int unsigned GC_CAL_BIT  = 7;
  localparam int unsigned CH_IE_BIT   = 7;

  logic acc_rd, acc_wr;
  logic hit_ch, hit_stat, hit_res, hit_cfg, hit_gc, hit_gs, hit_pin;

  assign acc_rd   = bus_sel && !bus_wr;
  assign acc_wr   = bus_sel && bus_wr;
  assign hit_ch   = bus_addr == ADDR_W'(OFF_CHCTL);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  assign hit_res  = bus_addr == ADDR_W'(OFF_RES);
  assign hit_cfg  = bus_addr == ADDR_W'(OFF_CFG);
  assign hit_gc   = bus_addr == ADDR_W'(OFF_GCTL);
  assign hit_gs   = bus_addr == ADDR_W'(OFF_GSTAT);
  assign hit_pin  = bus_addr == ADDR_W'(OFF_PIN);

  logic [1:0]       mode_q, mode_n;
  logic             ovw_q, ovw_n;
  logic [PIN_W-1:0] pin_q, pin_n;

  always_comb begin
    mode_n = mode_q;
    ovw_n  = ovw_q;
    pin_n  = pin_q;
    if (acc_wr && hit_cfg) begin
      mode_n = bus_wdata[3:2];
      ovw_n  = bus_wdata[CFG_OVW_BIT];
    end
    if (acc_wr && hit_pin) pin_n = bus_wdata[PIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      ovw_q  <= 1'b0;
      pin_q  <= '0;
    end else begin
      mode_q <= mode_n;
      ovw_q  <= ovw_n;
      pin_q  <= pin_n;
    end
  end

  logic             cal_run, cal_fail, cal_set;
  logic [CH_W-1:0]  chan_q;
  logic             ie_q, flag_q;
  logic [RES_W-1:0] result_q;

  adc_regfront_cal u_cal (
    .clk            (clk),
    .rst_n          (rst_n),
    .gc_we          (acc_wr && hit_gc),
    .gc_cal         (bus_wdata[GC_CAL_BIT]),
    .core_cal_done  (core_cal_done),
    .core_cal_fail  (core_cal_fail),
    .core_cal_start (core_cal_start),
    .cal_run_q      (cal_run),
    .cal_fail_q     (cal_fail),
    .cal_set        (cal_set)
  );

  adc_regfront_conv u_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_we       (acc_wr && hit_ch),
    .ch_code     (bus_wdata[CH_W-1:0]),
    .ch_ie       (bus_wdata[CH_IE_BIT]),
    .rd_res      (acc_rd && hit_res),
    .cal_set     (cal_set),
    .ovw_en      (ovw_q),
    .core_done   (core_done),
    .core_result (core_result),
    .core_start  (core_start),
    .chan_q      (chan_q),
    .ie_q        (ie_q),
    .flag_q      (flag_q),
    .result_q    (result_q)
  );

  assign core_chan = chan_q;
  assign irq       = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      if (hit_ch) begin
        bus_rdata[CH_W-1:0]  = chan_q;
        bus_rdata[CH_IE_BIT] = ie_q;
      end
      if (hit_stat) bus_rdata[0] = flag_q;
      if (hit_res)  bus_rdata[RES_W-1:0] = result_q & res_mask(mode_q);
      if (hit_cfg) begin
        bus_rdata[3:2]         = mode_q;
        bus_rdata[CFG_OVW_BIT] = ovw_q;
      end
      if (hit_gc)  bus_rdata[GC_CAL_BIT] = cal_run;
      if (hit_gs)  bus_rdata[1] = cal_fail;
      if (hit_pin) bus_rdata[PIN_W-1:0] = pin_q;
    end
  end

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ie_q && flag_q);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !(hit_ch || hit_stat || hit_res || hit_cfg || hit_gc || hit_gs || hit_pin))
      |-> bus_rdata == 32'd0);

endmodule

// File: tb/adc_regfront_test.sv
`timescale 1ns/1ps
module adc_regfront_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, core_start, core_cal_start;
  logic [4:0]  core_chan;
  logic        core_done = 1'b0, core_cal_done = 1'b0, core_cal_fail = 1'b0;
  logic [11:0] core_result = '0;

  always #4 clk = ~clk;

  adc_regfront uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .core_start(core_start), .core_chan(core_chan),
    .core_done(core_done), .core_result(core_result),
    .core_cal_start(core_cal_start), .core_cal_done(core_cal_done),
    .core_cal_fail(core_cal_fail)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int m_chan, m_ie, m_busy, m_flag, m_res, m_mode, m_ovw, m_pin;
  int m_cal, m_fail, m_start, m_calstart;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chan = 31; m_ie = 0; m_busy = 0; m_flag = 0; m_res = 0;
      m_mode = 0; m_ovw = 0; m_pin = 0; m_cal = 0; m_fail = 0;
      m_start = 0; m_calstart = 0;
    end else begin
      int got_done, rd_res, new_flag, wr;
      wr = bus_sel && bus_wr;
      rd_res = bus_sel && !bus_wr && bus_addr == 8'h0C;
      got_done = core_done && m_busy;
      new_flag = m_flag;
      m_start = 0; m_calstart = 0;
      if (got_done) begin
        m_busy = 0;
        if (!m_flag || m_ovw || rd_res) m_res = core_result;
      end
      if (wr && bus_addr == 8'h00) begin
        m_chan = bus_wdata[4:0]; m_ie = bus_wdata[7];
        if (bus_wdata[4:0] != 5'h1F) begin m_start = 1; m_busy = 1; end
        else m_busy = 0;
      end
      if (rd_res) new_flag = 0;
      if (got_done) new_flag = 1;
      if (core_cal_done && m_cal) begin
        m_cal = 0; m_fail = core_cal_fail; new_flag = 1;
      end else if (wr && bus_addr == 8'h18 && bus_wdata[7] && !m_cal) begin
        m_cal = 1; m_fail = 0; m_calstart = 1;
      end
      m_flag = new_flag;
      if (wr && bus_addr == 8'h14) begin m_mode = bus_wdata[3:2]; m_ovw = bus_wdata[16]; end
      if (wr && bus_addr == 8'h30) m_pin = bus_wdata;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v;
    v = 0;
    case (a)
      8'h00: v = (m_ie << 7) | m_chan;
      8'h08: v = m_flag;
      8'h0C: v = m_res & (m_mode == 0 ? 32'hFF : m_mode == 1 ? 32'h3FF : 32'hFFF);
      8'h14: v = (m_ovw << 16) | (m_mode << 2);
      8'h18: v = m_cal << 7;
      8'h1C: v = m_fail << 1;
      8'h30: v = m_pin;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of pulses and interrupt
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(core_start === m_start[0], "R2 start pulse", core_start, m_start);
      if (m_start) chk(core_chan === m_chan[4:0], "R2 channel", core_chan, m_chan);
      chk(core_cal_start === m_calstart[0], "R9 cal pulse", core_cal_start, m_calstart);
      chk(irq === (m_flag && m_ie), "R4 irq", irq, m_flag && m_ie);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    e = exp_rd(a);
    chk(bus_rdata === e, req, bus_rdata, e);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_fixed(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(bus_rdata === e, req, bus_rdata, e);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic done(input logic [11:0] r);
    @(negedge clk);
    core_done = 1; core_result = r;
    @(negedge clk);
    core_done = 0;
  endtask

  task automatic caldone(input logic f);
    @(negedge clk);
    core_cal_done = 1; core_cal_fail = f;
    @(negedge clk);
    core_cal_done = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_fixed(8'h00, 32'h1F, "R1 chctl reset");
    rd_fixed(8'h08, 32'h0, "R1 status reset");
    rd_fixed(8'h0C, 32'h0, "R1 result reset");
    rd_fixed(8'h14, 32'h0, "R1 cfg reset");
    rd_fixed(8'h1C, 32'h0, "R1 gstat reset");
    chk(irq === 1'b0, "R1 irq reset", irq, 0);
    // R11 cfg keeps only its fields
    wr(8'h14, 32'hFFFF_FFFB);
    rd_fixed(8'h14, 32'h0001_0008, "R11 cfg fields");
    // R2/R4/R5 basic conversion, 12-bit, ie on
    wr(8'h00, 32'h83);
    chk(core_start === 1'b1 && core_chan === 5'd3, "R2 start after write", {core_start, core_chan}, {1'b1, 5'd3});
    done(12'hABC);
    chk(irq === 1'b1, "R4 irq on done", irq, 1);
    rd_fixed(8'h08, 32'h1, "R4 status set");
    rd_fixed(8'h0C, 32'hABC, "R5 result value");
    chk(irq === 1'b0, "R5 irq cleared", irq, 0);
    rd_fixed(8'h08, 32'h0, "R5 status cleared");
    // R8 resolution masks
    wr(8'h14, 32'h0001_0000);
    wr(8'h00, 32'h05);
    done(12'hFFF);
    rd_fixed(8'h0C, 32'hFF, "R8 8-bit mask");
    wr(8'h14, 32'h0001_0004);
    wr(8'h00, 32'h05);
    done(12'hFFF);
    rd_fixed(8'h0C, 32'h3FF, "R8 10-bit mask");
    wr(8'h14, 32'h0001_000C);
    wr(8'h00, 32'h05);
    done(12'h5A5);
    rd_fixed(8'h0C, 32'h5A5, "R8 code 11 is 12-bit");
    // R6 overwrite enabled
    wr(8'h00, 32'h05); done(12'h111);
    wr(8'h00, 32'h05); done(12'h222);
    rd_fixed(8'h0C, 32'h222, "R6 overwrite");
    // R7 overwrite disabled
    wr(8'h14, 32'h0000_0008);
    wr(8'h00, 32'h05); done(12'h333);
    wr(8'h00, 32'h05); done(12'h444);
    rd_fixed(8'h0C, 32'h333, "R7 old result kept");
    rd_fixed(8'h08, 32'h0, "R7 status after read");
    // R3 stop code
    wr(8'h00, 32'h9F);
    chk(core_start === 1'b0, "R3 no start on stop", core_start, 0);
    done(12'h555);
    rd_fixed(8'h08, 32'h0, "R3 done ignored when stopped");
    rd_fixed(8'h00, 32'h9F, "R3 chctl readback");
    wr(8'h00, 32'h82);
    wr(8'h00, 32'h9F);
    done(12'h666);
    rd_fixed(8'h08, 32'h0, "R3 stop cancels conversion");
    rd_fixed(8'h0C, 32'h333, "R3 result unchanged");
    // R9/R10 calibration
    wr(8'h18, 32'h80);
    chk(core_cal_start === 1'b1, "R9 cal start pulse", core_cal_start, 1);
    rd_fixed(8'h18, 32'h80, "R9 cal running");
    wr(8'h18, 32'h80);
    chk(core_cal_start === 1'b0, "R9 write while running ignored", core_cal_start, 0);
    caldone(1'b1);
    rd_fixed(8'h18, 32'h0, "R9 cal bit self-clears");
    rd_fixed(8'h1C, 32'h2, "R10 fail latched");
    chk(irq === 1'b1, "R10 cal irq", irq, 1);
    rd_fixed(8'h08, 32'h1, "R10 status set by cal");
    rd(8'h0C, "R5 read clears after cal");
    wr(8'h18, 32'h80);
    rd_fixed(8'h1C, 32'h0, "R10 fail cleared on new run");
    caldone(1'b0);
    rd_fixed(8'h1C, 32'h0, "R10 pass");
    // R11 unmapped offsets and pin control
    wr(8'h04, 32'hFFFF_FFFF);
    rd_fixed(8'h04, 32'h0, "R11 unmapped read zero");
    rd_fixed(8'h20, 32'h0, "R11 unmapped read zero 0x20");
    rd_fixed(8'h14, 32'h0000_0008, "R11 cfg untouched by unmapped write");
    wr(8'h30, 32'hDEAD_BEEF);
    rd_fixed(8'h30, 32'hDEAD_BEEF, "R11 pin control storage");
    rd(8'h00, "R11 chctl vs model");
    repeat (4) @(negedge clk);
    summary();
  end

endmodule